// File: doc/BRIEF.md
# Programmable Memory Cycle Timing Generator

This block shapes the control strobes of one external memory access. A client raises a request together with a read/write direction. At that moment the block captures a memory-type select and four phase-length bits, called U, V, W and Z here. It then plays out one complete access and pulses a completion flag in the access's final clock.

For dynamic RAM it drives a row strobe and a column strobe, both active-low. For static RAM it drives chip-select, output-enable and write-enable, all active-low. It also produces a bus-drive enable for the shared address/data pins. That enable drops in the last clock of every access so the bus floats before the next one. Between accesses the enable follows an idle-drive control input.

The block runs from a 15 ns clock, so one 30 ns phase unit is two clocks and one 60 ns unit is four clocks. Any phase-length bit that is clear gives two clocks, and one that is set gives four.

Top module: `mem_cycle_timer`

## Requirements
- R1: While reset is held, every strobe is high, `busy` and `done` are low, and `bus_drive_en` equals `idle_drive`.
- R2: Each phase-length bit selects 2 clocks when 0 and 4 clocks when 1. A DRAM access therefore lasts between 8 and 16 clocks.
- R3: In DRAM mode (`dram_mode`=1), counting clocks from 0 after acceptance, `ras_n` falls at clock Tu. `cas_n` falls Tv clocks later and rises after Tw further clocks. The access ends Tz clocks after that. `ras_n` is high in the final clock, and `cas_n` is never low while `ras_n` is high.
- R4: An SRAM write (`dram_mode`=0, `req_write`=1) has one idle clock, then `ce_n` and `we_n` low for Tu+Tv clocks, then one closing clock. `oe_n` stays high throughout.
- R5: An SRAM read (`dram_mode`=0, `req_write`=0) holds `ce_n` and `oe_n` low from clock 0 for Tw+Tz clocks, then two clocks with all strobes high. `we_n` stays high throughout.
- R6: `bus_drive_en` is low in the final clock of every access and high in every other clock of the access.
- R7: When no access is running, `bus_drive_en` equals `idle_drive`.
- R8: Mode, direction and phase bits are captured when a request is accepted. Changing them during an access does not alter it.
- R9: A request is accepted only while `busy` is low. `busy` is then high for exactly the access length, and a request raised during an access is dropped rather than queued.
- R10: `done` is high for exactly one clock, the final clock of each access.
- R11: During a DRAM access `ce_n`, `oe_n` and `we_n` stay high. During an SRAM access `ras_n` and `cas_n` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 15 ns period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| dram_mode | input | 1 | 1 = DRAM timing, 0 = SRAM timing |
| cfg_u | input | 1 | First phase length select |
| cfg_v | input | 1 | Second phase length select |
| cfg_w | input | 1 | Third phase length select |
| cfg_z | input | 1 | Fourth phase length select |
| idle_drive | input | 1 | Bus drive state between accesses |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| ce_n | output | 1 | SRAM chip select, active low |
| oe_n | output | 1 | SRAM output enable, active low |
| we_n | output | 1 | SRAM write enable, active low |
| bus_drive_en | output | 1 | Drive the memory address/data bus |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final-clock pulse of an access |

## Verification
The bench rebuilds each expected strobe waveform clock by clock by joining phase segments, and compares it with the outputs. It covers the all-short, all-long and mixed phase codes in each of the three access kinds. A design that swapped two phase bits or miscounted the SRAM setup or tail clocks would show a strobe edge one or more clocks out of place. The bench flips every configuration input in the middle of an access to catch a design that reads its inputs live instead of holding what it captured. It also raises a request in the middle of an access to catch one that queues or restarts. The final-clock float, and the idle-drive level with both polarities, are checked so that a bus left driven into the next access is seen.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  parameter int TIME_W = 6;
  typedef logic [TIME_W-1:0] tick_t;

  typedef enum logic [1:0] {
    KIND_DRAM    = 2'd0,
    KIND_SRAM_WR = 2'd1,
    KIND_SRAM_RD = 2'd2
  } cyc_kind_e;

  // Positions within an access, counted in clocks from 0.
  typedef struct packed {
    tick_t t_a;    // first strobe edge
    tick_t t_b;    // second strobe edge
    tick_t t_c;    // third strobe edge
    tick_t t_end;  // access length
  } bounds_t;

  function automatic tick_t phase_len(input logic sel, input tick_t short_c, input tick_t long_c);
    return sel ? long_c : short_c;
  endfunction

  function automatic bounds_t plan_bounds(input cyc_kind_e k,
                                          input tick_t tu, input tick_t tv,
                                          input tick_t tw, input tick_t tz,
                                          input tick_t float_c, input tick_t short_c);
    bounds_t b;
    case (k)
      KIND_DRAM: begin
        b.t_a   = tu;
        b.t_b   = tu + tv;
        b.t_c   = tu + tv + tw;
        b.t_end = tu + tv + tw + tz;
      end
      KIND_SRAM_WR: begin
        b.t_a   = float_c;
        b.t_b   = float_c + tu + tv;
        b.t_c   = float_c + tu + tv;
        b.t_end = float_c + tu + tv + float_c;
      end
      default: begin
        b.t_a   = '0;
        b.t_b   = tw + tz;
        b.t_c   = tw + tz;
        b.t_end = tw + tz + short_c;
      end
    endcase
    return b;
  endfunction
endpackage

// File: rtl/mtg_cfg_latch.sv
module mtg_cfg_latch
  import mtg_pkg::*;
#(
  parameter int SHORT_CLKS = 2,
  parameter int LONG_CLKS  = 4,
  parameter int FLOAT_CLKS = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_evt,
  input  logic      req_write,
  input  logic      dram_mode,
  input  logic      cfg_u,
  input  logic      cfg_v,
  input  logic      cfg_w,
  input  logic      cfg_z,
  output cyc_kind_e cur_kind,
  output bounds_t   cur_bounds
);
  localparam tick_t SHORT_T = tick_t'(SHORT_CLKS);
  localparam tick_t LONG_T  = tick_t'(LONG_CLKS);
  localparam tick_t FLOAT_T = tick_t'(FLOAT_CLKS);

  cyc_kind_e nxt_kind;
  bounds_t   nxt_bounds;

  always_comb begin
    if (dram_mode)      nxt_kind = KIND_DRAM;
    else if (req_write) nxt_kind = KIND_SRAM_WR;
    else                nxt_kind = KIND_SRAM_RD;
    nxt_bounds = plan_bounds(nxt_kind,
                             phase_len(cfg_u, SHORT_T, LONG_T),
                             phase_len(cfg_v, SHORT_T, LONG_T),
                             phase_len(cfg_w, SHORT_T, LONG_T),
                             phase_len(cfg_z, SHORT_T, LONG_T),
                             FLOAT_T, SHORT_T);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind   <= KIND_DRAM;
      cur_bounds <= '0;
    end else if (start_evt) begin
      cur_kind   <= nxt_kind;
      cur_bounds <= nxt_bounds;
    end
  end
endmodule

// File: rtl/mtg_seq.sv
module mtg_seq
  import mtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  tick_t end_pos,
  output logic  busy,
  output tick_t pos,
  output logic  start_evt,
  output logic  last_evt
);
  assign start_evt = req_valid && !busy;
  assign last_evt  = busy && (pos == end_pos - tick_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
    end else if (start_evt) begin
      busy <= 1'b1;
      pos  <= '0;
    end else if (last_evt) begin
      busy <= 1'b0;
      pos  <= '0;
    end else if (busy) begin
      pos  <= pos + tick_t'(1);
    end
  end
endmodule

// File: rtl/mtg_strobe_dec.sv
module mtg_strobe_dec
  import mtg_pkg::*;
(
  input  logic      busy,
  input  logic      last_evt,
  input  logic      idle_drive,
  input  cyc_kind_e cur_kind,
  input  bounds_t   cur_bounds,
  input  tick_t     pos,
  output logic      ras_n,
  output logic      cas_n,
  output logic      ce_n,
  output logic      oe_n,
  output logic      we_n,
  output logic      bus_drive_en
);
  logic is_dram, win_ab, win_bc, past_a;

  always_comb begin
    is_dram = (cur_kind == KIND_DRAM);
    past_a  = pos >= cur_bounds.t_a;
    win_ab  = past_a && (pos < cur_bounds.t_b);
    win_bc  = (pos >= cur_bounds.t_b) && (pos < cur_bounds.t_c);

    ras_n = !(busy && is_dram && past_a && !last_evt);
    cas_n = !(busy && is_dram && win_bc);
    ce_n  = !(busy && !is_dram && win_ab);
    we_n  = !(busy && (cur_kind == KIND_SRAM_WR) && win_ab);
    oe_n  = !(busy && (cur_kind == KIND_SRAM_RD) && win_ab);

    bus_drive_en = busy ? !last_evt : idle_drive;
  end
endmodule

// File: rtl/mem_cycle_timer.sv
module mem_cycle_timer
  import mtg_pkg::*;
#(
  parameter int SHORT_CLKS = 2,
  parameter int LONG_CLKS  = 4,
  parameter int FLOAT_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic dram_mode,
  input  logic cfg_u,
  input  logic cfg_v,
  input  logic cfg_w,
  input  logic cfg_z,
  input  logic idle_drive,
  output logic ras_n,
  output logic cas_n,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic bus_drive_en,
  output logic busy,
  output logic done
);
  cyc_kind_e cur_kind;
  bounds_t   cur_bounds;
  tick_t     pos;
  logic      start_evt;
  logic      last_evt;

  mtg_cfg_latch #(
    .SHORT_CLKS(SHORT_CLKS), .LONG_CLKS(LONG_CLKS), .FLOAT_CLKS(FLOAT_CLKS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
    .req_write(req_write), .dram_mode(dram_mode),
    .cfg_u(cfg_u), .cfg_v(cfg_v), .cfg_w(cfg_w), .cfg_z(cfg_z),
    .cur_kind(cur_kind), .cur_bounds(cur_bounds)
  );

  mtg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .end_pos(cur_bounds.t_end), .busy(busy), .pos(pos),
    .start_evt(start_evt), .last_evt(last_evt)
  );

  mtg_strobe_dec u_dec (
    .busy(busy), .last_evt(last_evt), .idle_drive(idle_drive),
    .cur_kind(cur_kind), .cur_bounds(cur_bounds), .pos(pos),
    .ras_n(ras_n), .cas_n(cas_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .bus_drive_en(bus_drive_en)
  );

  assign done = last_evt;
endmodule

// File: rtl/mtg_checker.sv
module mtg_checker
  import mtg_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      req_valid,
  input logic      idle_drive,
  input logic      ras_n,
  input logic      cas_n,
  input logic      ce_n,
  input logic      oe_n,
  input logic      we_n,
  input logic      bus_drive_en,
  input logic      busy,
  input logic      done,
  input cyc_kind_e cur_kind,
  input bounds_t   cur_bounds
);
  assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_we_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));

  assert_oe_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));

  assert_end_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_drive_en && ras_n && cas_n && ce_n));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_drive_en == idle_drive));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(cur_bounds) && $stable(cur_kind)));

  assert_start_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_dram_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_kind == KIND_DRAM) |-> (ce_n && oe_n && we_n));

  assert_sram_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_kind != KIND_DRAM) |-> (ras_n && cas_n));
endmodule

bind mem_cycle_timer mtg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .idle_drive(idle_drive),
  .ras_n(ras_n), .cas_n(cas_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .bus_drive_en(bus_drive_en), .busy(busy), .done(done),
  .cur_kind(cur_kind), .cur_bounds(cur_bounds)
);

// File: tb/tb_mem_cycle_timer.sv
module tb_mem_cycle_timer;
  localparam int PERIOD = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, dram_mode = 1'b0;
  logic cfg_u = 1'b0, cfg_v = 1'b0, cfg_w = 1'b0, cfg_z = 1'b0;
  logic idle_drive = 1'b1;
  logic ras_n, cas_n, ce_n, oe_n, we_n, bus_drive_en, busy, done;

  int total = 0;
  int bad = 0;
  logic [4:0] exp_s [0:31];
  int exp_n;

  always #(PERIOD/2.0) clk = ~clk;

  mem_cycle_timer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .dram_mode(dram_mode), .cfg_u(cfg_u), .cfg_v(cfg_v), .cfg_w(cfg_w),
    .cfg_z(cfg_z), .idle_drive(idle_drive), .ras_n(ras_n), .cas_n(cas_n),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .bus_drive_en(bus_drive_en),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input int n, input logic [4:0] v);
    for (int k = 0; k < n; k++) begin
      exp_s[exp_n] = v;
      exp_n++;
    end
  endtask

  function automatic int clks(input logic b);
    return b ? 4 : 2;
  endfunction

  // Expected strobes {ras_n,cas_n,ce_n,oe_n,we_n}, built by segment.
  task automatic build(input logic dm, input logic wr,
                       input logic u, input logic v, input logic w, input logic z);
    exp_n = 0;
    if (dm) begin
      push(clks(u), 5'b11111);
      push(clks(v), 5'b01111);
      push(clks(w), 5'b00111);
      push(clks(z), 5'b01111);
      exp_s[exp_n-1] = 5'b11111;
    end else if (wr) begin
      push(1, 5'b11111);
      push(clks(u) + clks(v), 5'b11010);
      push(1, 5'b11111);
    end else begin
      push(clks(w) + clks(z), 5'b11001);
      push(2, 5'b11111);
    end
  endtask

  // Runs one access and compares every clock. disturb: 1 = flip config mid-access,
  // 2 = raise a request mid-access.
  task automatic run_access(input string tag, input logic dm, input logic wr,
                            input logic u, input logic v, input logic w, input logic z,
                            input int disturb);
    build(dm, wr, u, v, w, z);
    @(negedge clk);
    dram_mode = dm; req_write = wr;
    cfg_u = u; cfg_v = v; cfg_w = w; cfg_z = z;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      chk(tag, {3'b0, ras_n, cas_n, ce_n, oe_n, we_n}, {3'b0, exp_s[i]});
      chk("R6", {7'b0, bus_drive_en}, {7'b0, (i != exp_n - 1)});
      chk("R10", {7'b0, done}, {7'b0, (i == exp_n - 1)});
      chk("R9", {7'b0, busy}, 8'd1);
      if (disturb == 1 && i == 1) begin
        dram_mode = ~dm; req_write = ~wr;
        cfg_u = ~u; cfg_v = ~v; cfg_w = ~w; cfg_z = ~z;
      end
      if (disturb == 2) req_valid = (i == 2);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R9", {7'b0, busy}, 8'd0);
    chk("R7", {7'b0, bus_drive_en}, {7'b0, idle_drive});
    if (disturb == 2) begin
      @(negedge clk);
      chk("R9", {7'b0, busy}, 8'd0);
      @(negedge clk);
      chk("R9", {7'b0, busy}, 8'd0);
    end
  endtask

  task automatic test_reset();
    #(PERIOD * 2);
    @(negedge clk);
    chk("R1", {ras_n, cas_n, ce_n, oe_n, we_n, busy, done, bus_drive_en}, 8'b11111_001);
    rst_n = 1'b1;
  endtask

  task automatic test_phase_sweep();
    run_access("R2", 1, 0, 0, 0, 0, 0, 0);
    run_access("R2", 1, 1, 1, 1, 1, 1, 0);
  endtask

  task automatic test_dram_mixed();
    run_access("R3", 1, 0, 1, 0, 1, 0, 0);
    run_access("R3", 1, 1, 0, 1, 0, 1, 0);
    run_access("R11", 1, 0, 0, 0, 1, 1, 0);
  endtask

  task automatic test_sram_write();
    run_access("R4", 0, 1, 0, 0, 1, 1, 0);
    run_access("R4", 0, 1, 0, 1, 0, 0, 0);
    run_access("R4", 0, 1, 1, 0, 0, 0, 0);
    run_access("R11", 0, 1, 1, 1, 0, 0, 0);
  endtask

  task automatic test_sram_read();
    run_access("R5", 0, 0, 1, 1, 0, 0, 0);
    run_access("R5", 0, 0, 0, 0, 0, 1, 0);
    run_access("R5", 0, 0, 0, 0, 1, 0, 0);
    run_access("R5", 0, 0, 0, 0, 1, 1, 0);
  endtask

  task automatic test_idle_level();
    @(negedge clk);
    idle_drive = 1'b0;
    #1;
    chk("R7", {7'b0, bus_drive_en}, 8'd0);
    run_access("R7", 1, 0, 0, 1, 0, 0, 0);
    idle_drive = 1'b1;
    #1;
    chk("R7", {7'b0, bus_drive_en}, 8'd1);
  endtask

  task automatic test_cfg_change();
    run_access("R8", 1, 0, 0, 1, 1, 0, 1);
    run_access("R8", 0, 1, 1, 0, 0, 0, 1);
  endtask

  task automatic test_busy_drop();
    run_access("R9", 0, 0, 1, 1, 1, 0, 2);
  endtask

  initial begin
    #(PERIOD * 50000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_phase_sweep();
    test_dram_mixed();
    test_sram_write();
    test_sram_read();
    test_idle_level();
    test_cfg_change();
    test_busy_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule